// File: doc/BRIEF.md
# Push-Button Offset Accumulator

This block keeps a bounded, non-negative step count that two push-button inputs move up and down, and adds that count to a 16-bit sample stream. A typical use is nudging the vertical position of a trace on a display: each press of the "raise" button moves the trace by one unit, and each press of the "lower" button moves it back by one unit.

Each button passes through one register stage and is then compared with its previous registered value. A step is taken only on a 0-to-1 transition, so holding a button down gives exactly one step. The count feeds an offset register that is reloaded from the count on every clock, not only on button events. A change of direction therefore shows up on the next refresh, with no stale extra step. When the raise input changes state in the same cycle that a lower press arrives, the raise input wins. The lower press is kept pending and is serviced on the following cycle.

The sample path is a valid/ready stream with no storage. An output beat is offered whenever an input beat is offered, and back-pressure from the consumer reaches the producer combinationally. A beat transfers in a cycle where both valid and ready are high, and it carries the offset register value of that same cycle.

Top module: `offs_accum`

## Requirements
- R1: A synchronous active-high reset clears the count, the offset register and both button history registers, so after reset `m_data` equals `s_data`.
- R2: A 0-to-1 change on `inc_btn` raises the count by one. With the input high before clock edge k, `m_data` still shows the old offset after edges k and k+1, and shows the new offset after edge k+2.
- R3: A 0-to-1 change on `dec_btn` lowers the count by one, with the same three-edge latency as R2.
- R4: Holding a button high, or releasing it, produces no further step.
- R5: The offset register is reloaded from the count every clock. After k raise presses and then one lower press, the output shows k-1, not k+1 or k.
- R6: The count saturates at 512. A raise press at 512 leaves it at 512.
- R7: The count saturates at 0. A lower press at 0 leaves it at 0.
- R8: If `inc_btn` changes state (either direction) in the cycle where a `dec_btn` rising edge is seen, the increment side is handled and the decrement is deferred by exactly one clock. It is not lost.
- R9: `m_data` equals `s_data` plus the zero-extended offset, modulo 2^16.
- R10: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in every cycle. The block adds no buffering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_btn | input | 1 | Raise button, level input |
| dec_btn | input | 1 | Lower button, level input |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready (copy of `m_ready`) |
| s_data | input | 16 | Input sample |
| m_valid | output | 1 | Output sample valid (copy of `s_valid`) |
| m_ready | input | 1 | Output sample ready from consumer |
| m_data | output | 16 | Sample plus offset, modulo 2^16 |

## Verification
A wrong count or a wrong button history shows up at `m_data` as an offset error within three clock edges of the press that caused it. Because that is within three clocks, each press is checked at a precise edge rather than only at the end. A stale offset register after a change of direction would leave the output one step off in the second direction. A mishandled deferral in the simultaneous case would shift the final decrement by one edge, or drop it, so the output is sampled both at the edge where the deferred step is still pending and at the edge after it lands. The saturation limits are reached by real press sequences, and one extra press is applied at each limit.

// File: rtl/offs_pkg.sv
package offs_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/offs_btn_edge.sv
// One button: a single sampling register plus a history register.
// The history register is frozen while hold is high, so a pending
// rising edge stays visible on the next cycle.
module offs_btn_edge (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  input  logic hold,
  output logic changed,
  output logic rise
);
  logic btn_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      btn_q <= btn;
      if (!hold) prev_q <= btn_q;
    end
  end

  assign changed = btn_q ^ prev_q;
  assign rise    = btn_q & ~prev_q;
endmodule

// File: rtl/offs_step_counter.sv
// Saturating up/down step counter between 0 and CNT_MAX.
module offs_step_counter
  import offs_pkg::*;
#(
  parameter int CNT_MAX = 512,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (step)
      STEP_UP:   if (cnt_q != TOP)        cnt_d = cnt_q + CNT_W'(1);
      STEP_DOWN: if (cnt_q != '0)         cnt_d = cnt_q - CNT_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/offs_sum.sv
// Offset register, reloaded from the count every clock, and the sample adder.
module offs_sum #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] sample,
  output logic [CNT_W-1:0]  offset,
  output logic [DATA_W-1:0] result
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) ofs_q <= '0;
    else     ofs_q <= count;
  end

  assign offset = ofs_q;
  assign result = sample + {{PAD_W{1'b0}}, ofs_q};
endmodule

// File: rtl/offs_accum.sv
module offs_accum
  import offs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_MAX = 512,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_btn,
  input  logic              dec_btn,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  localparam int NBTN = 2;

  logic [NBTN-1:0] btn_in;
  logic [NBTN-1:0] btn_hold;
  logic [NBTN-1:0] btn_chg;
  logic [NBTN-1:0] btn_rise;
  step_e           step;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] ofs_w;

  assign btn_in = {dec_btn, inc_btn};

  // Button 0 (raise) has priority; button 1 (lower) keeps its history
  // frozen while button 0 is changing, so its edge is deferred.
  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    if (g == 0) begin : g_first
      assign btn_hold[g] = 1'b0;
    end else begin : g_later
      assign btn_hold[g] = |btn_chg[g-1:0];
    end
    offs_btn_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .btn    (btn_in[g]),
      .hold   (btn_hold[g]),
      .changed(btn_chg[g]),
      .rise   (btn_rise[g])
    );
  end

  always_comb begin
    if (btn_rise[0])                      step = STEP_UP;
    else if (btn_rise[1] && !btn_hold[1]) step = STEP_DOWN;
    else                                  step = STEP_HOLD;
  end

  offs_step_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .count(cnt_w)
  );

  offs_sum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .count (cnt_w),
    .sample(s_data),
    .offset(ofs_w),
    .result(m_data)
  );

  assign m_valid = s_valid;
  assign s_ready = m_ready;
endmodule

// File: rtl/offs_accum_chk.sv
module offs_accum_chk #(
  parameter int CNT_MAX = 512,
  parameter int CNT_W   = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] offset
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == '0 && offset == '0)); // R1
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + CNT_W'(1)) || (count == $past(count) - CNT_W'(1))); // R2
  AST_OFFSET_TRACKS: assert property (@(posedge clk) disable iff (rst) offset == $past(count)); // R5
  AST_CEILING: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(CNT_MAX)); // R6
  AST_VALID_PASS: assert property (@(posedge clk) disable iff (rst) m_valid == s_valid); // R10
  AST_READY_PASS: assert property (@(posedge clk) disable iff (rst) s_ready == m_ready); // R10
endmodule

bind offs_accum offs_accum_chk #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .count  (cnt_w),
  .offset (ofs_w)
);

// File: tb/sim_offs_accum.sv
module sim_offs_accum;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_btn = 1'b0;
  logic        dec_btn = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = 16'h0000;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  offs_accum u0 (
    .clk(clk), .rst(rst), .inc_btn(inc_btn), .dec_btn(dec_btn),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // {op[1:0], sample[15:0], expected count[9:0]}; op 1 = raise, 2 = lower, 0 = idle
  localparam int NVEC = 10;
  localparam logic [27:0] VEC [0:NVEC-1] = '{
    {2'd1, 16'h0100, 10'd1},
    {2'd1, 16'h0200, 10'd2},
    {2'd1, 16'h0000, 10'd3},
    {2'd2, 16'h1234, 10'd2},
    {2'd2, 16'h0000, 10'd1},
    {2'd0, 16'h8000, 10'd1},
    {2'd2, 16'h0000, 10'd0},
    {2'd2, 16'h0005, 10'd0},
    {2'd1, 16'hFFFF, 10'd1},
    {2'd1, 16'hFFFE, 10'd2}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic press(input bit up);
    @(negedge clk);
    if (up) inc_btn = 1'b1; else dec_btn = 1'b1;
    repeat (4) @(negedge clk);
    inc_btn = 1'b0;
    dec_btn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    s_data = 16'h4321;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", m_data, 16'h4321);

    // R10: handshake pass-through
    s_valid = 1'b1; m_ready = 1'b0; #1;
    check("R10 valid high", {15'd0, m_valid}, 16'd1);
    check("R10 ready low", {15'd0, s_ready}, 16'd0);
    s_valid = 1'b0; m_ready = 1'b1; #1;
    check("R10 valid low", {15'd0, m_valid}, 16'd0);
    check("R10 ready high", {15'd0, s_ready}, 16'd1);

    // Vector table: R2 R3 R4 R5 R7 R9
    s_valid = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic [15:0] exp;
      op     = VEC[i][27:26];
      s_data = VEC[i][25:10];
      exp    = VEC[i][25:10] + {6'd0, VEC[i][9:0]};
      if (op == 2'd1)      press(1'b1);
      else if (op == 2'd2) press(1'b0);
      else                 repeat (4) @(negedge clk);
      check($sformatf("R2 R3 R5 R7 R9 vector %0d", i), m_data, exp);
    end

    // R2 latency and R4 hold / release
    do_reset();
    s_data = 16'h0000;
    inc_btn = 1'b1;
    @(negedge clk);
    check("R2 after edge k", m_data, 16'd0);
    @(negedge clk);
    check("R2 after edge k+1", m_data, 16'd0);
    @(negedge clk);
    check("R2 after edge k+2", m_data, 16'd1);
    repeat (5) @(negedge clk);
    check("R4 held button", m_data, 16'd1);
    inc_btn = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 released button", m_data, 16'd1);

    // R3 latency for the lower button
    dec_btn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 after edge k+1", m_data, 16'd1);
    @(negedge clk);
    check("R3 after edge k+2", m_data, 16'd0);
    dec_btn = 1'b0;
    repeat (4) @(negedge clk);

    // R8: both rise together, raise first, lower one clock later
    inc_btn = 1'b1; dec_btn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 raise serviced first", m_data, 16'd1);
    @(negedge clk);
    check("R8 deferred lower lands", m_data, 16'd0);
    inc_btn = 1'b0; dec_btn = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 both released", m_data, 16'd0);

    // R8: raise released while lower pressed
    press(1'b1);
    check("R8 setup count", m_data, 16'd1);
    inc_btn = 1'b1;
    repeat (4) @(negedge clk);
    inc_btn = 1'b0; dec_btn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 lower still pending", m_data, 16'd2);
    @(negedge clk);
    check("R8 lower applied", m_data, 16'd1);
    dec_btn = 1'b0;
    repeat (4) @(negedge clk);

    // R6: upper saturation
    do_reset();
    for (int i = 0; i < 513; i++) begin
      inc_btn = 1'b1;
      @(negedge clk);
      inc_btn = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R6 ceiling reached", m_data, 16'd512);
    press(1'b1);
    check("R6 press at ceiling", m_data, 16'd512);
    press(1'b0);
    check("R6 step down from ceiling", m_data, 16'd511);

    // R1: reset in mid-run
    s_data = 16'h00AA;
    do_reset();
    check("R1 mid-run reset", m_data, 16'h00AA);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule